// File: doc/BRIEF.md
# Vector Type Configuration Decoder

This block turns a requested vector configuration into the values the rest of a vector unit depends on. The request is an element-width code, a group-multiplier code, tail and mask policy flags, a requested application vector length and a clamp option. The block returns four derived values: the element width in bits, the multiplier scaled by eight, the largest element count a register group can hold, and the granted vector length. It also returns an illegal-configuration flag and a flag telling whether the doubled pair (twice the width, twice the multiplier) would be legal.

The multiplier can be a fraction. To avoid fractions it is carried as eight times its value. Legality of each width/multiplier pair comes from a 64-bit parameter table, so one RTL serves several vector unit sizes. A request is taken on a valid strobe. The results appear on registered outputs one cycle later and hold until the next strobe.

Top module: `vcfg_decoder`

## Requirements
- R1: The multiplier code maps to the scaled multiplier as follows: codes 0, 1, 2 and 3 give 8, 16, 32 and 64; codes 5, 6 and 7 give 1, 2 and 4; the reserved code 4 gives 0.
- R2: The element width in bits is 8 shifted left by the 3-bit width code, so codes 0 to 7 give 8 to 1024.
- R3: The maximum element count is (scaled multiplier × REG_BYTES) divided by the element width in bits, rounded down. It is reported even for illegal pairs.
- R4: A pair is legal when bit {width code, multiplier code} of LEGAL_MAP is set. Width code is bits 5:3 of that index and multiplier code is bits 2:0. Multiplier code 4 is always illegal. An illegal pair sets the illegal flag and forces both policy outputs to 0. A legal pair passes the policy flags through.
- R5: When the illegal flag is set, the granted length is 0.
- R6: On a legal pair, a requested length no greater than the maximum count is granted unchanged.
- R7: On a legal pair with clamping enabled, a requested length above the maximum count is granted as the maximum count.
- R8: On a legal pair with clamping disabled, a requested length above the maximum count is handled in two ways. If it is below twice the maximum, the grant is half the request rounded up. Otherwise the grant is the maximum count.
- R9: The widening flag is 0 when the multiplier code is 3 or 4, or when the width code is 7. Otherwise it equals the table bit of the doubled pair, whose width code is one higher and whose multiplier code is the one with twice the scaled multiplier.
- R10: The tail bound is the larger of the maximum count and REG_BYTES×8 divided by the element width in bits.
- R11: A strobe seen at a rising edge updates every output at that edge, and the output valid signal goes high for exactly that one cycle. Without a strobe, all outputs hold their values.
- R12: After reset, the output valid signal is 0, the illegal flag is 1, and every other output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Request strobe |
| wcode_i | input | 3 | Element-width code |
| mcode_i | input | 3 | Group-multiplier code |
| tail_agn_i | input | 1 | Tail-agnostic policy request |
| mask_agn_i | input | 1 | Mask-agnostic policy request |
| avl_i | input | AVL_W | Requested application vector length |
| clamp_i | input | 1 | Clamp an over-long request straight to the maximum count |
| out_valid_o | output | 1 | One-cycle pulse marking fresh results |
| sew_bits_o | output | 11 | Element width in bits |
| mul_x8_o | output | 7 | Multiplier times eight |
| vlmax_o | output | VL_W | Maximum element count of the group |
| vl_o | output | VL_W | Granted vector length |
| tail_bound_o | output | VL_W | Upper element bound for tail handling |
| vill_o | output | 1 | Illegal configuration |
| wide_ok_o | output | 1 | Doubled pair is legal |
| tail_agn_o | output | 1 | Accepted tail-agnostic policy |
| mask_agn_o | output | 1 | Accepted mask-agnostic policy |

## Verification
Two functions can both act on the same request: the length grant and the legality decision. An over-long request paired with clamping on an illegal pair tests whether the illegal flag takes priority; the grant must be 0 and the policy outputs cleared, not the maximum count. A legal pair whose doubled form is illegal (the largest multiplier or an over-wide element) tests that the widening flag is computed separately from the base grant, with the base result still correct. Each case is sent as a table row and judged one cycle after its strobe.

// File: rtl/vcfg_pkg.sv
package vcfg_pkg;

    localparam int CODE_W  = 3;
    localparam int SEW_W   = 11;
    localparam int MULX8_W = 7;

    typedef logic [CODE_W-1:0] code_t;

    // Scaled multiplier for a multiplier code; reserved code yields 0.
    function automatic logic [MULX8_W-1:0] mulx8_of(code_t m);
        case (m)
            3'd0:    return 7'd8;
            3'd1:    return 7'd16;
            3'd2:    return 7'd32;
            3'd3:    return 7'd64;
            3'd5:    return 7'd1;
            3'd6:    return 7'd2;
            3'd7:    return 7'd4;
            default: return 7'd0;
        endcase
    endfunction

    // Default legality: element no wider than the widest supported element,
    // and element width no larger than multiplier times that widest element.
    function automatic logic [63:0] default_legal_map(int elen_bytes);
        logic [63:0] map;
        map = '0;
        for (int w = 0; w < 8; w++) begin
            for (int m = 0; m < 8; m++) begin
                int mx8;
                mx8 = int'(mulx8_of(code_t'(m)));
                if (m != 4 && (1 << w) <= elen_bytes && (8 << w) <= mx8 * elen_bytes)
                    map[w*8+m] = 1'b1;
            end
        end
        return map;
    endfunction

endpackage

// File: rtl/vcfg_scale.sv
module vcfg_scale
    import vcfg_pkg::*;
(
    input  code_t              wcode_i,
    input  code_t              mcode_i,
    output logic [SEW_W-1:0]   sew_bits_o,
    output logic [MULX8_W-1:0] mul_x8_o
);

    always_comb begin
        sew_bits_o = SEW_W'(8) << wcode_i;
        mul_x8_o   = mulx8_of(mcode_i);
    end

endmodule

// File: rtl/vcfg_legal.sv
module vcfg_legal
    import vcfg_pkg::*;
#(
    parameter logic [63:0] LEGAL_MAP = 64'h0
) (
    input  code_t wcode_i,
    input  code_t mcode_i,
    output logic  base_ok_o,
    output logic  wide_ok_o
);

    code_t wide_m;
    code_t wide_w;
    logic  room;

    always_comb begin
        base_ok_o = (mcode_i != 3'd4) && LEGAL_MAP[{wcode_i, mcode_i}];

        room   = 1'b1;
        wide_m = 3'd0;
        case (mcode_i)
            3'd0:    wide_m = 3'd1;
            3'd1:    wide_m = 3'd2;
            3'd2:    wide_m = 3'd3;
            3'd5:    wide_m = 3'd6;
            3'd6:    wide_m = 3'd7;
            3'd7:    wide_m = 3'd0;
            default: room   = 1'b0;   // x8 would exceed 64, or reserved
        endcase
        if (wcode_i == 3'd7)
            room = 1'b0;
        wide_w    = wcode_i + 3'd1;
        wide_ok_o = room && LEGAL_MAP[{wide_w, wide_m}];
    end

endmodule

// File: rtl/vcfg_length.sv
module vcfg_length
    import vcfg_pkg::*;
#(
    parameter int REG_BYTES = 16,
    parameter int AVL_W     = 32,
    parameter int VL_W      = 8
) (
    input  code_t              wcode_i,
    input  logic [MULX8_W-1:0] mul_x8_i,
    input  logic [AVL_W-1:0]   avl_i,
    input  logic               clamp_i,
    input  logic               vill_i,
    output logic [VL_W-1:0]    vlmax_o,
    output logic [VL_W-1:0]    vl_o,
    output logic [VL_W-1:0]    tail_o
);

    logic [3:0]       shamt;
    logic [VL_W-1:0]  single;
    logic [AVL_W:0]   avl_x;
    logic [AVL_W:0]   max_x;
    logic [AVL_W:0]   dbl_x;
    logic [AVL_W-1:0] half_up;

    always_comb begin
        shamt   = {1'b0, wcode_i} + 4'd3;
        vlmax_o = VL_W'((32'(mul_x8_i) * 32'(REG_BYTES)) >> shamt);
        single  = VL_W'(32'(REG_BYTES) >> wcode_i);
        tail_o  = (single > vlmax_o) ? single : vlmax_o;

        avl_x   = {1'b0, avl_i};
        max_x   = (AVL_W+1)'(vlmax_o);
        dbl_x   = max_x << 1;
        half_up = {1'b0, avl_i[AVL_W-1:1]} + AVL_W'(avl_i[0]);

        if (vill_i)
            vl_o = '0;
        else if (avl_x <= max_x)
            vl_o = VL_W'(avl_i);
        else if (clamp_i || avl_x >= dbl_x)
            vl_o = vlmax_o;
        else
            vl_o = VL_W'(half_up);
    end

endmodule

// File: rtl/vcfg_decoder.sv
module vcfg_decoder
    import vcfg_pkg::*;
#(
    parameter int          REG_BYTES = 16,
    parameter int          AVL_W     = 32,
    parameter logic [63:0] LEGAL_MAP = vcfg_pkg::default_legal_map(8),
    localparam int         VL_W      = $clog2(8*REG_BYTES+1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid_i,
    input  logic [2:0]         wcode_i,
    input  logic [2:0]         mcode_i,
    input  logic               tail_agn_i,
    input  logic               mask_agn_i,
    input  logic [AVL_W-1:0]   avl_i,
    input  logic               clamp_i,
    output logic               out_valid_o,
    output logic [10:0]        sew_bits_o,
    output logic [6:0]         mul_x8_o,
    output logic [VL_W-1:0]    vlmax_o,
    output logic [VL_W-1:0]    vl_o,
    output logic [VL_W-1:0]    tail_bound_o,
    output logic               vill_o,
    output logic               wide_ok_o,
    output logic               tail_agn_o,
    output logic               mask_agn_o
);

    typedef struct packed {
        logic               valid;
        logic [SEW_W-1:0]   sew;
        logic [MULX8_W-1:0] mx8;
        logic [VL_W-1:0]    vlmax;
        logic [VL_W-1:0]    vl;
        logic [VL_W-1:0]    tail;
        logic               vill;
        logic               wide;
        logic               ta;
        logic               ma;
    } res_t;

    res_t res_d, res_q;

    logic [SEW_W-1:0]   sew_c;
    logic [MULX8_W-1:0] mx8_c;
    logic               base_ok_c, wide_ok_c;
    logic [VL_W-1:0]    vlmax_c, vl_c, tail_c;

    vcfg_scale u_scale (
        .wcode_i    (wcode_i),
        .mcode_i    (mcode_i),
        .sew_bits_o (sew_c),
        .mul_x8_o   (mx8_c)
    );

    vcfg_legal #(.LEGAL_MAP(LEGAL_MAP)) u_legal (
        .wcode_i   (wcode_i),
        .mcode_i   (mcode_i),
        .base_ok_o (base_ok_c),
        .wide_ok_o (wide_ok_c)
    );

    vcfg_length #(.REG_BYTES(REG_BYTES), .AVL_W(AVL_W), .VL_W(VL_W)) u_length (
        .wcode_i  (wcode_i),
        .mul_x8_i (mx8_c),
        .avl_i    (avl_i),
        .clamp_i  (clamp_i),
        .vill_i   (!base_ok_c),
        .vlmax_o  (vlmax_c),
        .vl_o     (vl_c),
        .tail_o   (tail_c)
    );

    always_comb begin
        res_d       = res_q;
        res_d.valid = 1'b0;
        if (in_valid_i) begin
            res_d.valid = 1'b1;
            res_d.sew   = sew_c;
            res_d.mx8   = mx8_c;
            res_d.vlmax = vlmax_c;
            res_d.vl    = vl_c;
            res_d.tail  = tail_c;
            res_d.vill  = !base_ok_c;
            res_d.wide  = wide_ok_c;
            res_d.ta    = tail_agn_i && base_ok_c;
            res_d.ma    = mask_agn_i && base_ok_c;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q      <= '0;
            res_q.vill <= 1'b1;
        end else begin
            res_q <= res_d;
        end
    end

    assign out_valid_o  = res_q.valid;
    assign sew_bits_o   = res_q.sew;
    assign mul_x8_o     = res_q.mx8;
    assign vlmax_o      = res_q.vlmax;
    assign vl_o         = res_q.vl;
    assign tail_bound_o = res_q.tail;
    assign vill_o       = res_q.vill;
    assign wide_ok_o    = res_q.wide;
    assign tail_agn_o   = res_q.ta;
    assign mask_agn_o   = res_q.ma;

    // R5: an illegal configuration never grants elements
    p_vill_no_length_r5: assert property (@(posedge clk) disable iff (!rst_n)
        vill_o |-> (vl_o == '0));

    // R6: granted length never exceeds the group capacity
    p_vl_in_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |-> (vl_o <= vlmax_o));

    // R4: reserved multiplier (scaled value 0) is always illegal
    p_reserved_illegal_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && mul_x8_o == 7'd0) |-> vill_o);

    // R4: policy flags are dropped on an illegal pair
    p_policy_cleared_r4: assert property (@(posedge clk) disable iff (!rst_n)
        vill_o |-> (!tail_agn_o && !mask_agn_o));

    // R9: the largest multiplier has no room to widen
    p_wide_needs_room_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && mul_x8_o == 7'd64) |-> !wide_ok_o);

    // R10: tail bound covers the whole group
    p_tail_floor_r10: assert property (@(posedge clk) disable iff (!rst_n)
        tail_bound_o >= vlmax_o);

    // R11: a result pulse follows a strobe
    p_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |-> $past(in_valid_i));

    // R11: without a strobe the results hold
    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(in_valid_i) |-> ($stable(vl_o) && $stable(vill_o) && $stable(vlmax_o)));

endmodule

// File: tb/test_vcfg_decoder.sv
module test_vcfg_decoder;

    localparam int AVL_W = 32;
    localparam int VL_W  = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic [2:0]       wcode = '0, mcode = '0;
    logic             ta = 1'b0, ma = 1'b0, clamp = 1'b0;
    logic [AVL_W-1:0] avl = '0;
    logic             out_valid, vill, wide_ok, ta_o, ma_o;
    logic [10:0]      sew_bits;
    logic [6:0]       mul_x8;
    logic [VL_W-1:0]  vlmax, vl, tail;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    vcfg_decoder i_vcfg_decoder (
        .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid),
        .wcode_i(wcode), .mcode_i(mcode), .tail_agn_i(ta), .mask_agn_i(ma),
        .avl_i(avl), .clamp_i(clamp),
        .out_valid_o(out_valid), .sew_bits_o(sew_bits), .mul_x8_o(mul_x8),
        .vlmax_o(vlmax), .vl_o(vl), .tail_bound_o(tail), .vill_o(vill),
        .wide_ok_o(wide_ok), .tail_agn_o(ta_o), .mask_agn_o(ma_o)
    );

    typedef struct packed {
        logic [2:0]  w;
        logic [2:0]  m;
        logic        ta;
        logic        ma;
        logic        clamp;
        logic [31:0] avl;
        logic [10:0] sew;
        logic [6:0]  mx8;
        logic [7:0]  vlmax;
        logic [7:0]  vl;
        logic [7:0]  tail;
        logic        vill;
        logic        wide;
    } row_t;

    // Register of 16 bytes; default legality table.
    localparam int NROWS = 15;
    localparam row_t VEC [NROWS] = '{
        '{3'd0,3'd0,1'b0,1'b0,1'b1,32'd5,         11'd8,   7'd8,  8'd16,8'd5, 8'd16,1'b0,1'b1},
        '{3'd2,3'd1,1'b0,1'b0,1'b1,32'd100,       11'd32,  7'd16, 8'd8, 8'd8, 8'd8, 1'b0,1'b1},
        '{3'd2,3'd1,1'b0,1'b0,1'b0,32'd12,        11'd32,  7'd16, 8'd8, 8'd6, 8'd8, 1'b0,1'b1},
        '{3'd2,3'd1,1'b0,1'b0,1'b0,32'd13,        11'd32,  7'd16, 8'd8, 8'd7, 8'd8, 1'b0,1'b1},
        '{3'd2,3'd1,1'b0,1'b0,1'b0,32'd16,        11'd32,  7'd16, 8'd8, 8'd8, 8'd8, 1'b0,1'b1},
        '{3'd0,3'd5,1'b0,1'b0,1'b1,32'd3,         11'd8,   7'd1,  8'd2, 8'd2, 8'd16,1'b0,1'b1},
        '{3'd1,3'd5,1'b1,1'b1,1'b1,32'd50,        11'd16,  7'd1,  8'd1, 8'd0, 8'd8, 1'b1,1'b0},
        '{3'd0,3'd4,1'b0,1'b0,1'b1,32'd7,         11'd8,   7'd0,  8'd0, 8'd0, 8'd16,1'b1,1'b0},
        '{3'd3,3'd3,1'b0,1'b0,1'b0,32'd40,        11'd64,  7'd64, 8'd16,8'd16,8'd16,1'b0,1'b0},
        '{3'd7,3'd0,1'b0,1'b0,1'b1,32'd9,         11'd1024,7'd8,  8'd0, 8'd0, 8'd0, 1'b1,1'b0},
        '{3'd3,3'd0,1'b0,1'b0,1'b1,32'd0,         11'd64,  7'd8,  8'd2, 8'd0, 8'd2, 1'b0,1'b0},
        '{3'd1,3'd7,1'b0,1'b0,1'b0,32'd4,         11'd16,  7'd4,  8'd4, 8'd4, 8'd8, 1'b0,1'b1},
        '{3'd0,3'd7,1'b1,1'b1,1'b0,32'd9,         11'd8,   7'd4,  8'd8, 8'd5, 8'd16,1'b0,1'b1},
        '{3'd0,3'd0,1'b0,1'b0,1'b0,32'hFFFF_FFFF, 11'd8,   7'd8,  8'd16,8'd16,8'd16,1'b0,1'b1},
        '{3'd1,3'd6,1'b0,1'b0,1'b0,32'd3,         11'd16,  7'd2,  8'd2, 8'd2, 8'd8, 1'b0,1'b1}
    };

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic apply(row_t r);
        @(negedge clk);
        wcode = r.w; mcode = r.m; ta = r.ta; ma = r.ma;
        clamp = r.clamp; avl = r.avl; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12: reset state
        check("R12 out_valid", int'(out_valid), 0);
        check("R12 vill", int'(vill), 1);
        check("R12 vl", int'(vl), 0);
        check("R12 vlmax", int'(vlmax), 0);
        check("R12 wide_ok", int'(wide_ok), 0);

        for (int i = 0; i < NROWS; i++) begin
            apply(VEC[i]);
            check("R11 out_valid pulse", int'(out_valid), 1);
            check("R2 sew_bits", int'(sew_bits), int'(VEC[i].sew));
            check("R1 mul_x8", int'(mul_x8), int'(VEC[i].mx8));
            check("R3 vlmax", int'(vlmax), int'(VEC[i].vlmax));
            check("R5 R6 R7 R8 vl", int'(vl), int'(VEC[i].vl));
            check("R10 tail bound", int'(tail), int'(VEC[i].tail));
            check("R4 vill", int'(vill), int'(VEC[i].vill));
            check("R9 wide_ok", int'(wide_ok), int'(VEC[i].wide));
            check("R4 tail policy", int'(ta_o), int'(VEC[i].ta & ~VEC[i].vill));
            check("R4 mask policy", int'(ma_o), int'(VEC[i].ma & ~VEC[i].vill));
        end

        // R11: pulse lasts one cycle; results hold without a strobe
        @(negedge clk);
        check("R11 pulse ends", int'(out_valid), 0);
        wcode = 3'd0; mcode = 3'd4; avl = 32'd1; clamp = 1'b1;
        repeat (3) @(negedge clk);
        check("R11 hold vl", int'(vl), 2);
        check("R11 hold vill", int'(vill), 0);
        check("R11 hold vlmax", int'(vlmax), 2);
        check("R11 no pulse", int'(out_valid), 0);

        // R11: back-to-back strobes each update at their own edge
        @(negedge clk);
        wcode = 3'd0; mcode = 3'd0; avl = 32'd3; clamp = 1'b1; in_valid = 1'b1;
        @(negedge clk);
        check("R6 first of pair", int'(vl), 3);
        avl = 32'd20; clamp = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check("R7 second of pair", int'(vl), 16);
        check("R11 valid stays high", int'(out_valid), 1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R11 watchdog actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule